// File: doc/BRIEF.md
# Conversion Queue Sequencer

This block runs a queue of conversion command words held in an external command RAM. A trigger strobe starts the queue at address zero. For each word the block issues a one-cycle conversion start with the word's channel number. It then waits for the converter's done strobe, which means the sample has been converted and its result stored. After that it moves to the next word. A word can carry a pause bit. The queue ends either on a word that holds the end-of-queue channel code or after the word at the top address of the RAM.

Two sticky flags record progress: a completion flag and a pause flag. Software reads the flags through a small register port. It acknowledges a flag by writing zero to it, but only after it has read that flag as one. Each flag can drive a shared interrupt request, which is reported together with a programmable level. In software-controlled mode the pause flag is still raised, but the queue does not stop at the pause.

Top module: `cq_sequencer`

## Requirements
- R1: After reset both flags read zero, the status is idle (`00`), `irq_req` and `conv_start` are low and `irq_level` is zero.
- R2: A `trig` pulse while idle starts the queue at address 0. The block issues one `conv_start` pulse per command word, in address order, with `conv_chan` equal to bits [CH_W-1:0] of that word. It does not issue the next start until `conv_done` has been seen for the current one.
- R3: A command word whose channel field is all ones is the end-of-queue code. When the word that follows a converted word is that code, the completion flag (register bit 0) is set on that conversion's done strobe and the queue goes idle. If the word at address 0 is the code, the queue returns to idle with no conversion and no flag set.
- R4: The conversion of the word at address DEPTH-1 ends the queue: the completion flag is set and the status returns to idle.
- R5: A word with its pause bit (bit CH_W) set raises the pause flag (register bit 1) on its done strobe, and the queue enters the paused state (`10`). While paused no conversion starts. A `trig` pulse resumes the queue at the next word. A `trig` while the queue is active has no effect.
- R6: If the word with the pause bit is the last word of the queue, the queue ends idle, not paused, and both flags are set.
- R7: With `sw_mode` high, a pause bit still raises the pause flag, but the queue carries on with the next word and never reports paused.
- R8: A read strobe records, for each flag, whether it read as one. A write clears a flag only where the write data bit is zero and that flag was recorded as read as one. A write with no such prior read has no effect, and writing a one has no effect.
- R9: When a flag set event and a qualifying clearing write fall in the same cycle, the flag stays set.
- R10: Flags are set whatever `irq_en` holds. `irq_req` is high one cycle after any flag is set whose enable bit (bit 0 for completion, bit 1 for pause) is high. It stays high until those flags clear. `irq_level` equals `irq_lvl_cfg` while `irq_req` is high and is zero otherwise.
- R11: `q_status` encodes idle as `00`, active as `01` and paused as `10`, and never shows `11`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Start or resume strobe |
| sw_mode | input | 1 | Software-controlled mode: pauses do not stop the queue |
| cmd_addr | output | AW | Command RAM read address |
| cmd_data | input | CH_W+1 | Command word read from the RAM: pause bit on top, channel below |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | CH_W | Channel for the requested conversion |
| conv_done | input | 1 | Conversion converted and stored |
| reg_rd | input | 1 | Flag register read strobe |
| reg_wr | input | 1 | Flag register write strobe |
| reg_wdata | input | 2 | Write data: bit 0 completion, bit 1 pause |
| reg_rdata | output | 2 | Flag read data: bit 0 completion, bit 1 pause |
| irq_en | input | 2 | Interrupt enables per flag |
| irq_lvl_cfg | input | LVL_W | Programmed interrupt level |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | LVL_W | Level of the pending request |
| q_status | output | 2 | Queue state |

## Verification
The bench targets the end-of-queue corners. It runs queues whose only word is the end code, queues that fill the RAM to the top address, and a pause on the final word. A design that checks the end only at issue time would start a phantom conversion, or run past address DEPTH-1, or park in paused instead of idle. It also runs a software-mode pause, where a wrong design would stall waiting for a trigger. It probes the acknowledge rule with writes of zero before any read and writes of one after a read, where a lax design would drop a flag. It also lands a clearing write in the same cycle as a completion, where a design that gives the clear priority would lose the new event. Random queues with pause bits, random done latencies and stray triggers during activity compare the sequence of converted channels and the final flags against a bench model.

// File: rtl/cq_sequencer.sv
module cq_sequencer #(
  parameter int CH_W  = 6,
  parameter int DEPTH = 16,
  parameter int LVL_W = 3,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = CH_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             sw_mode,
  output logic [AW-1:0]    cmd_addr,
  input  logic [CW-1:0]    cmd_data,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  input  logic             conv_done,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [1:0]       reg_wdata,
  output logic [1:0]       reg_rdata,
  input  logic [1:0]       irq_en,
  input  logic [LVL_W-1:0] irq_lvl_cfg,
  output logic             irq_req,
  output logic [LVL_W-1:0] irq_level,
  output logic [1:0]       q_status
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_PAUSE} st_t;

  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  st_t         st;
  logic [AW-1:0] ptr;
  logic        pbit;
  logic [1:0]  flg, mark;

  wire eoq     = &cmd_data[CH_W-1:0];
  wire done_ev = (st == S_WAIT) && conv_done;
  wire last_w  = (ptr == TOP) || eoq;
  wire [1:0] set_v = {done_ev && pbit, done_ev && last_w};
  wire [1:0] clr_v = {2{reg_wr}} & ~reg_wdata & mark;

  assign cmd_addr  = (st == S_WAIT && ptr != TOP) ? ptr + 1'b1 : ptr;
  assign reg_rdata = flg;
  assign irq_level = irq_req ? irq_lvl_cfg : '0;
  assign q_status  = (st == S_PAUSE) ? 2'b10 : (st == S_IDLE) ? 2'b00 : 2'b01;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ptr        <= '0;
      pbit       <= 1'b0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
    end else begin
      conv_start <= 1'b0;
      case (st)
        S_IDLE: if (trig) begin
          ptr <= '0;
          st  <= S_ISSUE;
        end
        S_ISSUE: if (eoq) st <= S_IDLE;
        else begin
          conv_start <= 1'b1;
          conv_chan  <= cmd_data[CH_W-1:0];
          pbit       <= cmd_data[CH_W];
          st         <= S_WAIT;
        end
        S_WAIT: if (conv_done) begin
          if (last_w) st <= S_IDLE;
          else begin
            ptr <= ptr + 1'b1;
            st  <= (pbit && !sw_mode) ? S_PAUSE : S_ISSUE;
          end
        end
        S_PAUSE: if (trig) st <= S_ISSUE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg     <= '0;
      mark    <= '0;
      irq_req <= 1'b0;
    end else begin
      flg     <= (flg & ~clr_v) | set_v;
      mark    <= reg_rd ? flg : (mark & ~clr_v);
      irq_req <= |(flg & irq_en);
    end
  end

  a_r11_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    q_status != 2'b11);

  a_r2_start_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> q_status == 2'b01);

  a_r7_no_pause_in_sw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_status == 2'b10) |-> $past(!sw_mode));

  a_r3_cf_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg[0]) |-> $past(conv_done));

  a_r8_cf_clear_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flg[0]) |-> $past(reg_wr && !reg_wdata[0] && mark[0]));

  a_r8_pf_clear_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flg[1]) |-> $past(reg_wr && !reg_wdata[1] && mark[1]));

  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(|(reg_rdata & irq_en)));

endmodule

// File: tb/cq_sequencer_tb_top.sv
`timescale 1ns/1ps
module cq_sequencer_tb_top;
  localparam int CH_W = 6, DEPTH = 16, LVL_W = 3, AW = 4, CW = 7;
  localparam logic [CH_W-1:0] EOQ = '1;

  logic clk = 0, rst_n = 0, trig = 0, sw_mode = 0, conv_done = 0;
  logic reg_rd = 0, reg_wr = 0;
  logic [1:0] reg_wdata = 0, irq_en = 0;
  logic [LVL_W-1:0] irq_lvl_cfg = 0;
  logic [AW-1:0] cmd_addr;
  logic [CW-1:0] cmd_data;
  logic conv_start, irq_req;
  logic [CH_W-1:0] conv_chan;
  logic [1:0] reg_rdata, q_status;
  logic [LVL_W-1:0] irq_level;
  logic [CW-1:0] mem [DEPTH];
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;
  assign cmd_data = mem[cmd_addr];

  cq_sequencer #(.CH_W(CH_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig(trig), .sw_mode(sw_mode),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_done(conv_done), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_en(irq_en), .irq_lvl_cfg(irq_lvl_cfg), .irq_req(irq_req),
    .irq_level(irq_level), .q_status(q_status));

  task automatic cyc; @(negedge clk); endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_eoq(input logic [CW-1:0] w);
    return w[CH_W-1:0] == EOQ;
  endfunction

  function automatic bit is_last(input int i);
    return (i == DEPTH - 1) || is_eoq(mem[i + 1]);
  endfunction

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic clear_flags;
    reg_rd = 1; cyc; reg_rd = 0;
    reg_wr = 1; reg_wdata = 2'b00; cyc; reg_wr = 0;
  endtask

  // runs the queue in mem, checking channels, status and final flags
  task automatic run_queue(input bit sw, input bit collide, input bit noise);
    bit pf = 0;
    int i = 0;
    bit fin = 0;
    sw_mode = sw;
    trig = 1; cyc; trig = 0;
    if (is_eoq(mem[0])) begin
      cyc;
      check(q_status == 2'b00, "R3 empty queue status", q_status, 0);
      check(reg_rdata == 2'b00, "R3 empty queue flags", reg_rdata, 0);
      return;
    end
    while (!fin) begin
      int guard = 0;
      while (!conv_start && guard < 20) begin
        trig = noise ? 1'($urandom % 2) : 1'b0;
        cyc; guard++;
      end
      trig = 0;
      check(guard < 20, "R2 conv_start seen", guard, 0);
      if (guard >= 20) return;
      check(conv_chan == mem[i][CH_W-1:0], "R2 channel order", conv_chan, mem[i][CH_W-1:0]);
      repeat ($urandom % 4) begin
        trig = noise ? 1'($urandom % 2) : 1'b0;
        cyc;
        check(!conv_start, "R2 no start before done", conv_start, 0);
      end
      trig = 0;
      conv_done = 1;
      if (collide && is_last(i)) begin reg_wr = 1; reg_wdata = 2'b00; end
      cyc;
      conv_done = 0; reg_wr = 0;
      pf |= mem[i][CH_W];
      if (is_last(i)) begin
        check(q_status == 2'b00, "R3/R4/R6 idle at end", q_status, 0);
        fin = 1;
      end else if (mem[i][CH_W] && !sw) begin
        check(q_status == 2'b10, "R5 paused", q_status, 2);
        repeat (3) begin
          cyc;
          check(!conv_start && q_status == 2'b10, "R5 holds while paused", q_status, 2);
        end
        trig = 1; cyc; trig = 0;
      end else begin
        check(q_status == 2'b01, "R7/R11 active after word", q_status, 1);
      end
      i++;
    end
    check(reg_rdata == {pf, 1'b1}, "R3/R5/R9 flags at end", reg_rdata, {pf, 1'b1});
    cyc;
    begin
      bit ei = |({pf, 1'b1} & irq_en);
      check(irq_req == ei, "R10 irq_req", irq_req, ei);
      check(irq_level == (ei ? irq_lvl_cfg : 3'd0), "R10 irq_level", irq_level, ei ? irq_lvl_cfg : 0);
    end
  endtask

  task automatic fill(input int n_words, input bit any_pause);
    for (int k = 0; k < DEPTH; k++) begin
      mem[k][CH_W-1:0] = CH_W'($urandom % 63);
      mem[k][CH_W] = any_pause && ($urandom % 4 == 0);
      if (k >= n_words) mem[k][CH_W-1:0] = EOQ;
    end
  endtask

  initial begin
    #(4 * 150000);
    check(0, "watchdog", 0, 1);
    summary;
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    fill(DEPTH, 0);
    repeat (3) cyc;
    rst_n = 1; cyc;
    // R1 reset state
    check(reg_rdata == 0, "R1 flags", reg_rdata, 0);
    check(q_status == 0, "R1 status", q_status, 0);
    check(!irq_req && irq_level == 0, "R1 irq", irq_req, 0);
    check(!conv_start, "R1 conv_start", conv_start, 0);

    // R3 empty queue
    fill(0, 0);
    run_queue(0, 0, 0);

    // R6 pause on last word, with irq level
    irq_en = 2'b10; irq_lvl_cfg = 3'd5;
    fill(2, 0); mem[1][CH_W] = 1;
    run_queue(0, 0, 0);

    // R8 acknowledge protocol
    reg_wr = 1; reg_wdata = 2'b00; cyc; reg_wr = 0; cyc;
    check(reg_rdata == 2'b11, "R8 write zero without read", reg_rdata, 3);
    reg_rd = 1; cyc; reg_rd = 0;
    reg_wr = 1; reg_wdata = 2'b11; cyc; reg_wr = 0; cyc;
    check(reg_rdata == 2'b11, "R8 write one ignored", reg_rdata, 3);
    reg_wr = 1; reg_wdata = 2'b10; cyc; reg_wr = 0; cyc;
    check(reg_rdata == 2'b10, "R8 clear completion only", reg_rdata, 2);
    reg_wr = 1; reg_wdata = 2'b00; cyc; reg_wr = 0; cyc;
    check(reg_rdata == 2'b00, "R8 clear pause", reg_rdata, 0);
    check(!irq_req, "R10 irq drops after clear", irq_req, 0);

    // R4 full RAM, R10 flags set with irq disabled
    irq_en = 2'b00;
    fill(DEPTH, 0);
    run_queue(0, 0, 0);
    clear_flags;

    // R5 mid-queue pause then resume, with stray triggers
    irq_en = 2'b01;
    fill(6, 0); mem[2][CH_W] = 1;
    run_queue(0, 0, 1);
    clear_flags;

    // R7 software mode
    fill(5, 0); mem[1][CH_W] = 1;
    run_queue(1, 0, 0);
    clear_flags;

    // R9 set beats clear
    fill(1, 0);
    run_queue(0, 0, 0);
    reg_rd = 1; cyc; reg_rd = 0;
    run_queue(0, 1, 0);
    clear_flags;

    // random queues
    for (int r = 0; r < 40; r++) begin
      irq_en = 2'($urandom);
      irq_lvl_cfg = 3'($urandom);
      fill(1 + $urandom % DEPTH, 1);
      run_queue(1'($urandom % 3 == 0), 0, 1);
      clear_flags;
      check(reg_rdata == 0, "R8 random clear", reg_rdata, 0);
    end

    summary;
    $finish;
  end
endmodule